// File: doc/BRIEF.md
# Four-State Transition-Output Sequencer

This block is a synchronous Mealy machine. It walks a fixed graph of four states, named A, B, C and D. Each step is driven by one input bit. The output is one of three symbols, and the symbol belongs to the transition being taken, not to the state. The output is combinational from the present state and the present input bit, so a symbol appears in the same cycle as the input that selects it. The next state is taken up on the rising clock edge.

A qualifier strobe marks the cycles in which the input bit counts. When the strobe is low, the machine keeps its state and drives the idle code. The present state is also brought out to a port for observation. A synchronous active-low reset returns the machine to A.

Top module: `mealy_seq_top`

## Requirements
- R1: While rst_n is low at a rising clock edge, the state becomes A (code 2'b00). The state codes are A=00, B=01, C=10 and D=11.
- R2: From A, with the bit at 0 the machine moves to B, and with the bit at 1 it moves to C. Both transitions emit symbol S1, code 2'b01.
- R3: From B, bit 0 keeps the machine in B and emits S2 (2'b10). Bit 1 moves it to D and emits S3 (2'b11).
- R4: From C, bit 0 moves the machine to D and emits S3 (2'b11). Bit 1 keeps it in C and emits S1 (2'b01).
- R5: From D, bit 0 keeps the machine in D and emits S3 (2'b11). Bit 1 keeps it in D and emits S2 (2'b10).
- R6: While the strobe is low, sym_out is 2'b00 and the state does not change at the clock edge, whatever the input bit is.
- R7: sym_out depends on the present state and the present inputs in the same cycle, with no register delay. A strobed cycle never drives 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_in | input | 1 | Input bit that picks the transition |
| bit_vld | input | 1 | Qualifier: the bit is used only while this is high |
| sym_out | output | 2 | Symbol for the transition (00 idle, 01 S1, 10 S2, 11 S3) |
| state_out | output | 2 | Present state code |

## Verification
The block has only the width parameters of its codes, so the bench builds it with the default 2-bit state and symbol widths. These widths expose every state code and every symbol code at the ports. That means all eight transitions, as well as the idle cycles, can be compared directly against a model built from the table. Random bit and strobe sequences reach D, which absorbs the machine, from both B and C. Resets issued mid-run bring the machine back to A, so the transitions out of A, B and C are exercised repeatedly.

// File: rtl/mealy_seq_pkg.sv
// Package: shared codes for the four-state sequencer.
// Assumes a 2-bit state code and a 2-bit symbol code.
package mealy_seq_pkg;
    localparam int ST_W  = 2;
    localparam int SYM_W = 2;

    typedef enum logic [ST_W-1:0] {
        ST_A = 2'b00,
        ST_B = 2'b01,
        ST_C = 2'b10,
        ST_D = 2'b11
    } state_t;

    typedef enum logic [SYM_W-1:0] {
        SYM_IDLE = 2'b00,
        SYM_S1   = 2'b01,
        SYM_S2   = 2'b10,
        SYM_S3   = 2'b11
    } sym_t;
endpackage

// File: rtl/mealy_seq_next.sv
// Module: next-state and transition-symbol table.
// Purely combinational. Assumes the caller gates the table with the strobe.
module mealy_seq_next
    import mealy_seq_pkg::*;
(
    input  state_t cur_st,
    input  logic   bit_in,
    output state_t nxt_st,
    output sym_t   tr_sym
);
    // Table lookup: one destination state and one symbol per (state, bit) pair.
    always_comb begin
        nxt_st = cur_st;
        tr_sym = SYM_S1;
        unique case (cur_st)
            ST_A: begin nxt_st = bit_in ? ST_C : ST_B; tr_sym = SYM_S1; end
            ST_B: begin nxt_st = bit_in ? ST_D : ST_B; tr_sym = bit_in ? SYM_S3 : SYM_S2; end
            ST_C: begin nxt_st = bit_in ? ST_C : ST_D; tr_sym = bit_in ? SYM_S1 : SYM_S3; end
            ST_D: begin nxt_st = ST_D;                  tr_sym = bit_in ? SYM_S2 : SYM_S3; end
            default: begin nxt_st = ST_A; tr_sym = SYM_IDLE; end
        endcase
    end
endmodule

// File: rtl/mealy_seq_reg.sv
// Module: state register with synchronous active-low reset and a load enable.
// Assumes the enable is the input strobe.
module mealy_seq_reg
    import mealy_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ld_en,
    input  state_t d_st,
    output state_t q_st
);
    // Holds the present state. Reset forces A; otherwise load only when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)     q_st <= ST_A;
        else if (ld_en) q_st <= d_st;
    end
endmodule

// File: rtl/mealy_seq_top.sv
// Module: four-state Mealy sequencer top.
// The output symbol is combinational from the state and the strobed bit.
// Assumes the inputs are synchronous to clk.
module mealy_seq_top
    import mealy_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             bit_vld,
    output logic [SYM_W-1:0] sym_out,
    output logic [ST_W-1:0]  state_out
);
    state_t cur_st, nxt_st;
    sym_t   tr_sym;

    mealy_seq_next u_next (.cur_st(cur_st), .bit_in(bit_in), .nxt_st(nxt_st), .tr_sym(tr_sym));
    mealy_seq_reg  u_reg  (.clk(clk), .rst_n(rst_n), .ld_en(bit_vld), .d_st(nxt_st), .q_st(cur_st));

    // Output gating: idle code while the strobe is low.
    always_comb begin
        sym_out   = bit_vld ? tr_sym : SYM_IDLE;
        state_out = cur_st;
    end
endmodule

// File: rtl/mealy_seq_chk.sv
// Module: property checker attached to the sequencer top.
// Assumes the port encodings given in the brief.
module mealy_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_in,
    input logic       bit_vld,
    input logic [1:0] sym_out,
    input logic [1:0] state_out
);
    AST_RESET_TO_A: assert property (@(posedge clk) !rst_n |=> state_out == 2'b00); // R1
    AST_A_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && state_out == 2'b00) |=> state_out == ($past(bit_in) ? 2'b10 : 2'b01)); // R2
    AST_B_SYM: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && state_out == 2'b01) |-> sym_out == (bit_in ? 2'b11 : 2'b10)); // R3
    AST_C_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && state_out == 2'b10) |=> state_out == ($past(bit_in) ? 2'b10 : 2'b11)); // R4
    AST_D_ABSORB: assert property (@(posedge clk) disable iff (!rst_n)
        (state_out == 2'b11) |=> state_out == 2'b11); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> $stable(state_out)); // R6
    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |-> sym_out == 2'b00); // R6
    AST_VLD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |-> sym_out != 2'b00); // R7
endmodule

bind mealy_seq_top mealy_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .sym_out(sym_out), .state_out(state_out)
);

// File: tb/sim_mealy_seq_top.sv
module sim_mealy_seq_top;
    logic clk = 0, rst_n = 0, bit_in = 0, bit_vld = 0;
    logic [1:0] sym_out, state_out;
    int checks = 0, fails = 0;
    logic [1:0] m_st;

    always #10 clk = ~clk;

    mealy_seq_top u0 (.clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
                      .sym_out(sym_out), .state_out(state_out));

    function automatic logic [1:0] exp_nxt(input logic [1:0] s, input logic b);
        case (s)
            2'b00: return b ? 2'b10 : 2'b01;
            2'b01: return b ? 2'b11 : 2'b01;
            2'b10: return b ? 2'b10 : 2'b11;
            default: return 2'b11;
        endcase
    endfunction

    function automatic logic [1:0] exp_sym(input logic [1:0] s, input logic b, input logic v);
        if (!v) return 2'b00;
        case (s)
            2'b00: return 2'b01;
            2'b01: return b ? 2'b11 : 2'b10;
            2'b10: return b ? 2'b01 : 2'b11;
            default: return b ? 2'b10 : 2'b11;
        endcase
    endfunction

    function automatic string req_of(input logic [1:0] s, input logic v);
        if (!v) return "R6";
        case (s)
            2'b00: return "R2";
            2'b01: return "R3";
            2'b10: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string r, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%b exp=%b", r, act, exp);
        end
    endtask

    // Drive a cycle after the falling edge, check sym (R7: same cycle), then check the state after the rising edge.
    task automatic step(input logic b, input logic v);
        @(negedge clk);
        bit_in = b; bit_vld = v;
        #1;
        chk({req_of(m_st, v), "/R7 sym"}, sym_out, exp_sym(m_st, b, v));
        if (v) m_st = exp_nxt(m_st, b);
        @(posedge clk); #1;
        chk({req_of(m_st, v), " state"}, state_out, m_st);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; bit_vld = 0;
        @(posedge clk); #1;
        m_st = 2'b00;
        chk("R1 reset", state_out, 2'b00);
        @(negedge clk); rst_n = 1;
    endtask

    initial begin
        #2_000_000;
        fails++; checks++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_st = 2'b00;
        do_reset();
        // Directed: A->B, stay in B, B->D, D outputs.
        step(0,1); step(0,1); step(1,1); step(1,1); step(0,1);
        step(1,0); step(0,0);              // R6 idle hold in D
        do_reset();
        step(1,1); step(1,1); step(1,0); step(0,1); step(1,1); // A->C, C stay, idle, C->D
        // Reset while in the middle of a walk.
        step(1,1); @(negedge clk); rst_n = 0; bit_vld = 1; bit_in = 1;
        @(posedge clk); #1; m_st = 2'b00; chk("R1 reset over strobe", state_out, 2'b00);
        @(negedge clk); rst_n = 1; bit_vld = 0;
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 16) == 0) do_reset();
            step($urandom % 2, ($urandom % 4) != 0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule